// File: doc/BRIEF.md
# Dual-Issue Packet Fetch Unit

This unit feeds a statically scheduled two-wide 32-bit core. Every cycle it reads one 64-bit packet from a synchronous instruction memory that has a read enable. It then splits the packet into two words. The lower word goes to the arithmetic/branch lane and the upper word goes to the memory-access lane. Both words are issued together in the same cycle, and the unit does no interlocking: the compiler is trusted to have kept the two words independent. An all-zero word is padding. It reaches its lane with the valid flag low. A packet whose words sit in the wrong lanes is rejected as a whole.

The branch lane redirects fetch by presenting a target while the branch packet is on the issue outputs. The packet that follows the branch is still issued, as a one-packet delay slot. One empty issue cycle then follows, and after it the target packet appears. A stall freezes the fetch address, the memory read and the issue outputs. A redirect that arrives during a stall is held in the unit and takes effect when the stall ends.

Top module: `dual_packet_fetch`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `imem_addr` equals the reset vector (default 0x100), both lane valid flags are low and both error flags are low.
- R2: With no stall and no redirect, `imem_addr` advances by 8 every cycle and its low three bits are always zero. A packet is issued two clock edges after its address was presented, with `issue_pc` equal to that address, so `imem_addr` runs 16 ahead of `issue_pc`.
- R3: Lane A receives packet bits [31:0] and lane B receives bits [63:32]. A word is classed as a nop when it is all zeros, as a memory access when bit 31 is 1, and as arithmetic/branch otherwise.
- R4: A nop word is issued with its lane valid low, and its instruction output is driven to zero.
- R5: A packet with a memory-class word in lane A or an arithmetic/branch-class word in lane B raises `err_illegal` for its issue cycle. Both valid flags are then low and both instruction outputs are zero.
- R6: A legal packet with two non-nop words raises both valid flags in the same cycle. Consecutive packets issue on consecutive cycles with no inserted gap.
- R7: A redirect presented while packet A is issued is followed by the packet at A+8 (delay slot), then one cycle with both valids low, then the packet at the target.
- R8: A redirect target whose low three bits are nonzero raises `err_misalign` in the next cycle for one cycle. The redirect is discarded and sequential issue continues with no gap.
- R9: While `stall` is high, `imem_en` is low, and `imem_addr` and all issue outputs keep their values. After release, the next packet in sequence issues on the following edge.
- R10: An aligned redirect presented while `stall` is high is held. After release it produces the same delay-slot, empty-cycle and target order as in R7, counted from the release cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall | input | 1 | Freeze fetch and issue |
| redir_valid | input | 1 | Branch lane requests a redirect |
| redir_target | input | ADDR_W | Redirect target address |
| imem_en | output | 1 | Instruction memory read enable |
| imem_addr | output | ADDR_W | Instruction memory packet address |
| imem_rdata | input | 64 | Packet read one cycle after the address |
| alu_valid | output | 1 | Lane A word is valid |
| alu_instr | output | 32 | Lane A word (arithmetic/branch) |
| ls_valid | output | 1 | Lane B word is valid |
| ls_instr | output | 32 | Lane B word (load/store) |
| issue_pc | output | ADDR_W | Address of the issued packet |
| err_illegal | output | 1 | Issued packet had a misplaced word |
| err_misalign | output | 1 | Last redirect target was misaligned |

## Verification
The critical collision is a redirect that arrives while a stall holds the pipeline. Two things happen in the same cycle: the redirect is captured, and the issue outputs are frozen. The bench raises the stall, presents an aligned target during the stall and then releases it. It judges the outcome by the order of issued packets after release: the delay slot, one empty cycle, then the target. It also checks that the held outputs never moved while the stall was on. A second overlap is between sequential issue and a redirect that gets rejected. Here a misaligned target must raise the error flag while the next sequential packets still issue without a gap.

// File: rtl/dpf_pkg.sv
package dpf_pkg;

   typedef enum logic [1:0] {
      CLS_NOP = 2'd0,
      CLS_ALU = 2'd1,
      CLS_MEM = 2'd2
   } slot_cls_e;

   localparam int LANES = 2;

endpackage

// File: rtl/dpf_pc_ctrl.sv
module dpf_pc_ctrl
   import dpf_pkg::*;
#(
   parameter int                ADDR_W     = 32,
   parameter int                ALIGN_BITS = 3,
   parameter logic [ADDR_W-1:0] RESET_VEC  = 'h100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stall,
   input  logic              redir_valid,
   input  logic [ADDR_W-1:0] redir_target,
   output logic [ADDR_W-1:0] fetch_addr,
   output logic [ADDR_W-1:0] resp_pc,
   output logic              resp_live,
   output logic              err_misalign
);

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1 << ALIGN_BITS);

   logic [ADDR_W-1:0] pc_q;
   logic [ADDR_W-1:0] hold_tgt_q;
   logic              hold_q;
   logic              tgt_aligned;
   logic              redir_ok;
   logic              jump_now;
   logic [ADDR_W-1:0] jump_tgt;

   assign tgt_aligned = (redir_target[ALIGN_BITS-1:0] == '0);
   assign redir_ok    = redir_valid && tgt_aligned;
   assign jump_now    = !stall && (redir_ok || hold_q);
   assign jump_tgt    = redir_ok ? redir_target : hold_tgt_q;
   assign fetch_addr  = pc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q         <= RESET_VEC;
         hold_q       <= 1'b0;
         hold_tgt_q   <= '0;
         resp_pc      <= '0;
         resp_live    <= 1'b0;
         err_misalign <= 1'b0;
      end else begin
         err_misalign <= redir_valid && !tgt_aligned;
         if (stall) begin
            if (redir_ok) begin
               hold_q     <= 1'b1;
               hold_tgt_q <= redir_target;
            end
         end else begin
            resp_pc   <= pc_q;
            resp_live <= !jump_now;
            pc_q      <= jump_now ? jump_tgt : pc_q + STEP;
            hold_q    <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/dpf_slot_check.sv
module dpf_slot_check
   import dpf_pkg::*;
#(
   parameter int INSTR_W  = 32,
   parameter int MEM_BIT  = 31,
   parameter int SLOT_IDX = 0
) (
   input  logic [INSTR_W-1:0] word_i,
   output slot_cls_e          cls_o,
   output logic               bad_o
);

   always_comb begin
      if (word_i == '0)
         cls_o = CLS_NOP;
      else if (word_i[MEM_BIT])
         cls_o = CLS_MEM;
      else
         cls_o = CLS_ALU;
   end

   generate
      if (SLOT_IDX == 0) begin : g_lane_a
         assign bad_o = (cls_o == CLS_MEM);
      end else begin : g_lane_b
         assign bad_o = (cls_o == CLS_ALU);
      end
   endgenerate

endmodule

// File: rtl/dpf_issue_reg.sv
module dpf_issue_reg
   import dpf_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int INSTR_W    = 32,
   parameter bit CLEAR_IDLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stall,
   input  logic              resp_live,
   input  logic [ADDR_W-1:0] resp_pc,
   input  logic [INSTR_W-1:0] word_a,
   input  logic [INSTR_W-1:0] word_b,
   input  slot_cls_e         cls_a,
   input  slot_cls_e         cls_b,
   input  logic              pkt_bad,
   output logic              alu_valid,
   output logic [INSTR_W-1:0] alu_instr,
   output logic              ls_valid,
   output logic [INSTR_W-1:0] ls_instr,
   output logic [ADDR_W-1:0] issue_pc,
   output logic              err_illegal
);

   logic               va_n;
   logic               vb_n;
   logic [INSTR_W-1:0] wa_n;
   logic [INSTR_W-1:0] wb_n;

   assign va_n = resp_live && !pkt_bad && (cls_a == CLS_ALU);
   assign vb_n = resp_live && !pkt_bad && (cls_b == CLS_MEM);

   generate
      if (CLEAR_IDLE) begin : g_clear
         assign wa_n = va_n ? word_a : '0;
         assign wb_n = vb_n ? word_b : '0;
      end else begin : g_pass
         assign wa_n = word_a;
         assign wb_n = word_b;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         alu_valid   <= 1'b0;
         ls_valid    <= 1'b0;
         alu_instr   <= '0;
         ls_instr    <= '0;
         issue_pc    <= '0;
         err_illegal <= 1'b0;
      end else if (!stall) begin
         alu_valid   <= va_n;
         ls_valid    <= vb_n;
         alu_instr   <= wa_n;
         ls_instr    <= wb_n;
         issue_pc    <= resp_pc;
         err_illegal <= resp_live && pkt_bad;
      end
   end

endmodule

// File: rtl/dual_packet_fetch.sv
module dual_packet_fetch
   import dpf_pkg::*;
#(
   parameter int                ADDR_W     = 32,
   parameter int                INSTR_W    = 32,
   parameter int                MEM_BIT    = 31,
   parameter bit                CLEAR_IDLE = 1'b1,
   parameter logic [ADDR_W-1:0] RESET_VEC  = 'h100
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 stall,
   input  logic                 redir_valid,
   input  logic [ADDR_W-1:0]    redir_target,
   output logic                 imem_en,
   output logic [ADDR_W-1:0]    imem_addr,
   input  logic [2*INSTR_W-1:0] imem_rdata,
   output logic                 alu_valid,
   output logic [INSTR_W-1:0]   alu_instr,
   output logic                 ls_valid,
   output logic [INSTR_W-1:0]   ls_instr,
   output logic [ADDR_W-1:0]    issue_pc,
   output logic                 err_illegal,
   output logic                 err_misalign
);

   localparam int PKT_W      = LANES * INSTR_W;
   localparam int ALIGN_BITS = $clog2(PKT_W / 8);

   generate
      if (RESET_VEC[ALIGN_BITS-1:0] != '0) begin : g_bad_vec
         $error("dual_packet_fetch: reset vector not packet aligned");
      end
      if (MEM_BIT >= INSTR_W) begin : g_bad_bit
         $error("dual_packet_fetch: class bit outside instruction word");
      end
      if (ADDR_W <= ALIGN_BITS) begin : g_bad_aw
         $error("dual_packet_fetch: address too narrow");
      end
   endgenerate

   logic [ADDR_W-1:0]  resp_pc;
   logic               resp_live;
   logic [INSTR_W-1:0] lane_word [LANES];
   slot_cls_e          lane_cls  [LANES];
   logic [LANES-1:0]   lane_bad;

   assign imem_en = !stall;

   dpf_pc_ctrl #(
      .ADDR_W     (ADDR_W),
      .ALIGN_BITS (ALIGN_BITS),
      .RESET_VEC  (RESET_VEC)
   ) u_pc (
      .clk          (clk),
      .rst_n        (rst_n),
      .stall        (stall),
      .redir_valid  (redir_valid),
      .redir_target (redir_target),
      .fetch_addr   (imem_addr),
      .resp_pc      (resp_pc),
      .resp_live    (resp_live),
      .err_misalign (err_misalign)
   );

   for (genvar s = 0; s < LANES; s++) begin : g_lane
      assign lane_word[s] = imem_rdata[s*INSTR_W +: INSTR_W];
      dpf_slot_check #(
         .INSTR_W  (INSTR_W),
         .MEM_BIT  (MEM_BIT),
         .SLOT_IDX (s)
      ) u_cls (
         .word_i (lane_word[s]),
         .cls_o  (lane_cls[s]),
         .bad_o  (lane_bad[s])
      );
   end

   dpf_issue_reg #(
      .ADDR_W     (ADDR_W),
      .INSTR_W    (INSTR_W),
      .CLEAR_IDLE (CLEAR_IDLE)
   ) u_issue (
      .clk         (clk),
      .rst_n       (rst_n),
      .stall       (stall),
      .resp_live   (resp_live),
      .resp_pc     (resp_pc),
      .word_a      (lane_word[0]),
      .word_b      (lane_word[1]),
      .cls_a       (lane_cls[0]),
      .cls_b       (lane_cls[1]),
      .pkt_bad     (|lane_bad),
      .alu_valid   (alu_valid),
      .alu_instr   (alu_instr),
      .ls_valid    (ls_valid),
      .ls_instr    (ls_instr),
      .issue_pc    (issue_pc),
      .err_illegal (err_illegal)
   );

endmodule

// File: rtl/dpf_checker.sv
module dpf_checker #(
   parameter int ADDR_W  = 32,
   parameter int INSTR_W = 32,
   parameter int MEM_BIT = 31
) (
   input logic               clk,
   input logic               rst_n,
   input logic               stall,
   input logic               redir_valid,
   input logic [ADDR_W-1:0]  redir_target,
   input logic [ADDR_W-1:0]  imem_addr,
   input logic               alu_valid,
   input logic [INSTR_W-1:0] alu_instr,
   input logic               ls_valid,
   input logic [INSTR_W-1:0] ls_instr,
   input logic [ADDR_W-1:0]  issue_pc,
   input logic               err_illegal,
   input logic               err_misalign
);

   // R2: fetch address stays packet aligned
   assert_aligned_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
      imem_addr[2:0] == 3'b000);

   // R9: a stalled cycle changes neither the fetch address nor the issue outputs
   assert_stall_holds_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> $stable(imem_addr));

   assert_stall_holds_issue_R9: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> ($stable(issue_pc) && $stable(alu_valid) && $stable(ls_valid)
                 && $stable(alu_instr) && $stable(ls_instr)));

   // R5: a rejected packet issues nothing
   assert_illegal_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      err_illegal |-> (!alu_valid && !ls_valid));

   // R8: misaligned target is flagged on the next cycle
   assert_misalign_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (redir_valid && redir_target[2:0] != 3'b000) |=> err_misalign);

   // R3: each valid lane carries a word of its own class
   assert_lane_a_class_R3: assert property (@(posedge clk) disable iff (!rst_n)
      alu_valid |-> (alu_instr != '0 && !alu_instr[MEM_BIT]));

   assert_lane_b_class_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ls_valid |-> ls_instr[MEM_BIT]);

endmodule

bind dual_packet_fetch dpf_checker #(
   .ADDR_W  (ADDR_W),
   .INSTR_W (INSTR_W),
   .MEM_BIT (MEM_BIT)
) u_dpf_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .stall        (stall),
   .redir_valid  (redir_valid),
   .redir_target (redir_target),
   .imem_addr    (imem_addr),
   .alu_valid    (alu_valid),
   .alu_instr    (alu_instr),
   .ls_valid     (ls_valid),
   .ls_instr     (ls_instr),
   .issue_pc     (issue_pc),
   .err_illegal  (err_illegal),
   .err_misalign (err_misalign)
);

// File: tb/dual_packet_fetch_test.sv
`timescale 1ns/1ps
module dual_packet_fetch_test;

   localparam logic [31:0] RV   = 32'h100;
   localparam int          NVEC = 9;
   // {exp lane A valid, exp lane B valid, exp illegal, lane B word, lane A word}
   localparam logic [66:0] VEC [NVEC] = '{
      {3'b110, 32'h8C22_0010, 32'h0123_4567},
      {3'b010, 32'hAC05_0004, 32'h0000_0000},
      {3'b100, 32'h0000_0000, 32'h0000_0020},
      {3'b000, 32'h0000_0000, 32'h0000_0000},
      {3'b001, 32'h8C01_0008, 32'h8C00_0004},
      {3'b001, 32'h1000_0002, 32'h2000_0001},
      {3'b001, 32'h0000_0001, 32'h0000_0000},
      {3'b001, 32'h0000_0000, 32'hAC00_0000},
      {3'b110, 32'hAC00_0008, 32'h1440_FFFE}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        stall = 1'b0;
   logic        redir_valid = 1'b0;
   logic [31:0] redir_target = '0;
   logic        imem_en;
   logic [31:0] imem_addr;
   logic [63:0] imem_rdata = '0;
   logic        alu_valid, ls_valid, err_illegal, err_misalign;
   logic [31:0] alu_instr, ls_instr, issue_pc;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   dual_packet_fetch uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .stall        (stall),
      .redir_valid  (redir_valid),
      .redir_target (redir_target),
      .imem_en      (imem_en),
      .imem_addr    (imem_addr),
      .imem_rdata   (imem_rdata),
      .alu_valid    (alu_valid),
      .alu_instr    (alu_instr),
      .ls_valid     (ls_valid),
      .ls_instr     (ls_instr),
      .issue_pc     (issue_pc),
      .err_illegal  (err_illegal),
      .err_misalign (err_misalign)
   );

   function automatic logic [63:0] pkt_of(input logic [31:0] a);
      logic [31:0] idx;
      idx = (a - RV) >> 3;
      if (a >= RV && idx < NVEC) return VEC[idx][63:0];
      return {8'h8C, a[23:0], 8'h01, a[23:0]};
   endfunction

   function automatic logic [31:0] dflt_a(input logic [31:0] a);
      return {8'h01, a[23:0]};
   endfunction

   function automatic logic [31:0] dflt_b(input logic [31:0] a);
      return {8'h8C, a[23:0]};
   endfunction

   always @(posedge clk) if (imem_en) imem_rdata <= pkt_of(imem_addr);

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // full check of a default packet on the issue outputs
   task automatic chk_pkt(input string req, input logic [31:0] a);
      chk(req, {issue_pc, 30'd0, alu_valid, ls_valid}, {a, 32'd3});
      chk(req, {ls_instr, alu_instr}, {dflt_b(a), dflt_a(a)});
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [31:0] a;
      logic [31:0] held_addr;
      repeat (3) @(posedge clk);
      // R1 reset state
      chk("R1 reset addr", imem_addr, RV);
      chk("R1 reset flags", {alu_valid, ls_valid, err_illegal, err_misalign}, 4'b0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1 first addr", imem_addr, RV);
      chk("R1 enable", imem_en, 1'b1);
      @(negedge clk);
      chk("R1 no issue yet", {alu_valid, ls_valid, err_illegal}, 3'b0);
      chk("R2 step", imem_addr, RV + 8);
      @(negedge clk);

      // table walk: R3 lane split, R4 nop, R5 illegal, R2 order
      for (int i = 0; i < NVEC; i++) begin
         logic ea, eb, ei;
         ea = VEC[i][66];
         eb = VEC[i][65];
         ei = VEC[i][64];
         chk("R2 issue_pc", issue_pc, RV + 32'(i * 8));
         chk("R2 lookahead", imem_addr, RV + 32'(i * 8) + 16);
         chk("R4 R5 valids", {alu_valid, ls_valid}, {ea, eb});
         chk("R5 illegal", err_illegal, ei);
         chk("R3 lane A word", alu_instr, ea ? VEC[i][31:0] : 32'h0);
         chk("R3 lane B word", ls_instr, eb ? VEC[i][63:32] : 32'h0);
         @(negedge clk);
      end

      // R6 back-to-back dual issue
      a = issue_pc;
      chk_pkt("R6 first", RV + 32'(NVEC * 8));
      for (int k = 1; k <= 3; k++) begin
         @(negedge clk);
         chk_pkt("R6 next", a + 32'(k * 8));
      end

      // R7 delay slot then bubble then target
      @(negedge clk);
      a = issue_pc;
      redir_valid = 1'b1;
      redir_target = 32'h2000;
      @(negedge clk);
      redir_valid = 1'b0;
      chk_pkt("R7 delay slot", a + 8);
      @(negedge clk);
      chk("R7 bubble", {alu_valid, ls_valid}, 2'b00);
      @(negedge clk);
      chk_pkt("R7 target", 32'h2000);
      @(negedge clk);
      chk_pkt("R7 after target", 32'h2008);

      // R8 misaligned redirect ignored
      a = issue_pc;
      redir_valid = 1'b1;
      redir_target = 32'h3004;
      @(negedge clk);
      redir_valid = 1'b0;
      chk("R8 flag", err_misalign, 1'b1);
      chk_pkt("R8 continues", a + 8);
      @(negedge clk);
      chk("R8 flag clears", err_misalign, 1'b0);
      chk_pkt("R8 no gap", a + 16);

      // R9 stall holds
      a = issue_pc;
      held_addr = imem_addr;
      stall = 1'b1;
      #1;
      chk("R9 enable low", imem_en, 1'b0);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk("R9 addr held", imem_addr, held_addr);
         chk_pkt("R9 issue held", a);
      end
      stall = 1'b0;
      @(negedge clk);
      chk_pkt("R9 resume", a + 8);

      // R10 redirect during stall
      a = issue_pc;
      stall = 1'b1;
      @(negedge clk);
      redir_valid = 1'b1;
      redir_target = 32'h4000;
      @(negedge clk);
      redir_valid = 1'b0;
      chk_pkt("R10 held during stall", a);
      @(negedge clk);
      stall = 1'b0;
      @(negedge clk);
      chk_pkt("R10 delay slot", a + 8);
      @(negedge clk);
      chk("R10 bubble", {alu_valid, ls_valid}, 2'b00);
      @(negedge clk);
      chk_pkt("R10 target", 32'h4000);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule